// File: doc/BRIEF.md
# Seven-to-one video lane serializer

This block turns a parallel video interface into a small number of serial lanes. Each pixel period it takes one 28-bit word: eight bits each of red, green and blue, the three timing signals (horizontal sync, vertical sync, data enable) and one spare bit. It sends that word out as seven serial slots on each data lane, next to a clock lane that carries a fixed framing pattern so the receiver can find word boundaries. Everything runs on one fast clock. A bit-slot enable pulses once per serial slot, at seven times the pixel rate. The pixel clock comes in as a level signal sampled in the same domain.

Software-free configuration pins pick the capture edge of the pixel clock, a narrow mode that drops the fourth lane for 18-bit panels, and a sleep state. Video has no back-pressure: a pixel is taken on every selected pixel-clock edge whether or not the previous one has been sent. The last captured word is the one sent in the next frame. A word that is overwritten before a frame boundary is never sent. If no new word arrives, the held word is sent again.

Top module: `ser7_video_tx`

## Requirements
- R1: With `rise_sel`=1 the word on `pix_word` is captured at a low-to-high change of `pix_clk`. With `rise_sel`=0 it is captured at a high-to-low change. The other edge captures nothing.
- R2: Word bits 7*L to 7*L+6 go to `lane_data[L]` (bits 0-6 lane 0, 7-13 lane 1, 14-20 lane 2, 21-27 lane 3). The highest bit of each group is sent in slot 0 and the lowest in slot 6.
- R3: A frame is seven slots. The lane outputs move to the next slot only in the cycle after `bit_en` is high, and hold their value otherwise.
- R4: `lane_clk` carries 1,1,0,0,0,1,1 over slots 0 to 6 of every frame, in step with the data lanes.
- R5: With `narrow_mode`=1, `lane_data[3]` stays low and word bits 21-27 have no effect on any output. Lanes 0-2 are unchanged. With `narrow_mode`=0 all four lanes are active.
- R6: One cycle after `wake` is low, every lane, including `lane_clk`, is low. It stays low for as long as `wake` stays low, and the slot position is reset. Pixel edges during sleep capture nothing.
- R7: After `wake` rises, all lanes stay low until a pixel has been captured. The first frame then begins at the next `bit_en` and carries that first captured word.
- R8: A captured word is loaded into the shifter only at a frame boundary. Each frame carries exactly one captured word, in capture order, even when the pixel period is not seven slots.
- R9: While `rst_n` is low and after reset with `wake` low, all lane outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock carrying the serial slot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per serial slot (seven per pixel) |
| pix_clk | input | 1 | Pixel clock level, sampled on `clk` |
| pix_word | input | 28 | Pixel word: colour, sync, enable, spare |
| rise_sel | input | 1 | 1 = capture on rising pixel edge, 0 = falling |
| narrow_mode | input | 1 | 1 = three data lanes, 0 = four |
| wake | input | 1 | 1 = active, 0 = sleep with lanes low |
| lane_data | output | 4 | Serial data lanes, one bit per slot |
| lane_clk | output | 1 | Framing clock lane |

## Verification
The bench drives a different word around each pixel-clock edge. A design that samples on the wrong edge then decodes the wrong half of each pair. A reversed slot order or a wrong lane mapping shows up as a bit-permuted word. A narrow-mode design that leaks bits 21-27 shows up as nonzero high bits in the decoded word. To catch a shifter that reads the capture register directly, a pixel period of ten slots makes captures land in the middle of frames, so any torn frame decodes to a word that was never sent. Sleep entered mid-frame and a wake with no pixel edges expose a design that keeps shifting, keeps stale captures, or restarts before a new word exists.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
package ser7_pkg;
  localparam int SER_RATIO = 7;
  localparam logic [SER_RATIO-1:0] FRAME_MARK = 7'b1100011;
  localparam int DATA_LANES = 4;
  localparam int SLIM_LANES = 3;
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
module ser7_capture #(
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              rise_sel,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] pix_word,
  output logic [WORD_W-1:0] held_word,
  output logic              word_seen
);
  logic pclk_d;
  logic take;

  // Edge detect on the sampled pixel clock; only the selected edge captures.
  always_comb begin
    if (rise_sel) take = pix_clk & ~pclk_d;
    else          take = ~pix_clk & pclk_d;
    take = take & awake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_d    <= 1'b0;
      held_word <= '0;
      word_seen <= 1'b0;
    end else begin
      pclk_d <= pix_clk;
      if (take) held_word <= pix_word;
      if (!awake)    word_seen <= 1'b0;
      else if (take) word_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/ser7_framer.sv
`timescale 1ns/1ps
module ser7_framer #(
  parameter int WORD_W    = 28,
  parameter int LANE_BITS = 7,
  localparam int SLOT_W   = $clog2(LANE_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              bit_en,
  input  logic              word_seen,
  input  logic [WORD_W-1:0] held_word,
  output logic [WORD_W-1:0] frame_word,
  output logic [SLOT_W-1:0] slot,
  output logic              running
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANE_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      slot       <= '0;
      frame_word <= '0;
    end else if (!awake) begin
      running <= 1'b0;
      slot    <= '0;
    end else if (bit_en) begin
      if (!running) begin
        if (word_seen) begin
          running    <= 1'b1;
          slot       <= '0;
          frame_word <= held_word;
        end
      end else if (slot == LAST_SLOT) begin
        slot       <= '0;
        frame_word <= held_word;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser7_lane_mux.sv
`timescale 1ns/1ps
module ser7_lane_mux #(
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 3,
  parameter int LANE_BITS    = 7,
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int SLOT_W = $clog2(LANE_BITS),
  localparam int WORD_W = LANES * LANE_BITS
) (
  input  logic [WORD_W-1:0] frame_word,
  input  logic [SLOT_W-1:0] slot,
  input  logic              running,
  input  logic              narrow,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_clk
);
  logic [SLOT_W-1:0] pick;
  // Slot 0 carries the top bit of each group.
  assign pick     = SLOT_W'(LANE_BITS - 1) - slot;
  assign lane_clk = running & CLK_PATTERN[pick];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] seg;
    assign seg = frame_word[l*LANE_BITS +: LANE_BITS];
    if (l >= NARROW_LANES) begin : g_gated
      assign lane_data[l] = running & ~narrow & seg[pick];
    end else begin : g_open
      assign lane_data[l] = running & seg[pick];
    end
  end
endmodule

// File: rtl/ser7_video_tx.sv
`timescale 1ns/1ps
module ser7_video_tx #(
  parameter int LANES        = ser7_pkg::DATA_LANES,
  parameter int NARROW_LANES = ser7_pkg::SLIM_LANES,
  parameter int LANE_BITS    = ser7_pkg::SER_RATIO,
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = ser7_pkg::FRAME_MARK,
  localparam int WORD_W = LANES * LANE_BITS,
  localparam int SLOT_W = $clog2(LANE_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] pix_word,
  input  logic              rise_sel,
  input  logic              narrow_mode,
  input  logic              wake,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_clk
);
  logic [WORD_W-1:0] held_word;
  logic              word_seen;
  logic [WORD_W-1:0] frame_word;
  logic [SLOT_W-1:0] slot;
  logic              running;

  ser7_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .awake(wake), .rise_sel(rise_sel),
    .pix_clk(pix_clk), .pix_word(pix_word),
    .held_word(held_word), .word_seen(word_seen)
  );

  ser7_framer #(.WORD_W(WORD_W), .LANE_BITS(LANE_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .awake(wake), .bit_en(bit_en),
    .word_seen(word_seen), .held_word(held_word),
    .frame_word(frame_word), .slot(slot), .running(running)
  );

  ser7_lane_mux #(
    .LANES(LANES), .NARROW_LANES(NARROW_LANES),
    .LANE_BITS(LANE_BITS), .CLK_PATTERN(CLK_PATTERN)
  ) u_mux (
    .frame_word(frame_word), .slot(slot), .running(running),
    .narrow(narrow_mode), .lane_data(lane_data), .lane_clk(lane_clk)
  );
endmodule

// File: rtl/ser7_video_tx_chk.sv
`timescale 1ns/1ps
module ser7_video_tx_chk #(
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             wake,
  input logic             narrow_mode,
  input logic [LANES-1:0] lane_data,
  input logic             lane_clk
);
  // Count sampled slots in a row with the clock lane low (saturating).
  logic [2:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (bit_en) begin
      if (lane_clk) low_run <= '0;
      else if (low_run != 3'd7) low_run <= low_run + 1'b1;
    end
  end

  a_r6_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> (lane_data == '0 && !lane_clk));

  a_r3_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && wake) |=> (($stable(lane_data) && $stable(lane_clk))
                           || !wake || !$stable(narrow_mode)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run >= 3'd4 && !lane_clk) |-> lane_data == '0);

  a_r5_top_lane_low: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_mode |-> lane_data[LANES-1:NARROW_LANES] == '0);
endmodule

bind ser7_video_tx ser7_video_tx_chk #(.LANES(LANES), .NARROW_LANES(NARROW_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wake(wake),
  .narrow_mode(narrow_mode), .lane_data(lane_data), .lane_clk(lane_clk)
);

// File: tb/ser7_video_tx_tb.sv
`timescale 1ns/1ps
module ser7_video_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        pix_clk = 1'b0;
  logic [27:0] pix_word = '0;
  logic        rise_sel = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        wake = 1'b0;
  logic [3:0]  lane_data;
  logic        lane_clk;

  int n_total = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [27:0] dec [0:63];
  int dec_n = 0;
  logic [6:0] win [0:4];

  always #2.5 clk = ~clk;

  ser7_video_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_clk(pix_clk),
    .pix_word(pix_word), .rise_sel(rise_sel), .narrow_mode(narrow_mode),
    .wake(wake), .lane_data(lane_data), .lane_clk(lane_clk)
  );

  // Slot enable every other cycle; sample each slot and decode frames
  // by spotting the clock-lane mark in a sliding window.
  initial for (int i = 0; i < 5; i++) win[i] = '0;
  always @(negedge clk) begin
    if (bit_en) begin
      for (int l = 0; l < 4; l++) win[l] = {win[l][5:0], lane_data[l]};
      win[4] = {win[4][5:0], lane_clk};
      if (win[4] == 7'b1100011 && dec_n < 64) begin
        dec[dec_n] = {win[3], win[2], win[1], win[0]};
        dec_n = dec_n + 1;
      end
    end
    bit_en = ~bit_en;
  end

  function automatic logic [27:0] wa(input int k, input int salt);
    return 28'(k * 32'h00B53A71 + 32'h01234567 + salt * 32'h00701F3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [27:0] act,
                     input logic [27:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pixels(input int n, input int half, input int salt);
    for (int k = 0; k < n; k++) begin
      pix_clk = 1'b1; pix_word = wa(k, salt);
      cycles(half);
      pix_clk = 1'b0; pix_word = ~wa(k, salt);
      cycles(half);
    end
  endtask

  task automatic restart(input bit rs, input bit nm);
    wake = 1'b0; pix_clk = 1'b0;
    rise_sel = rs; narrow_mode = nm;
    cycles(6);
    dec_n = 0;
    wake = 1'b1;
  endtask

  // R9: quiet outputs in and right after reset
  task automatic t_reset;
    cycles(1);
    chk({lane_data, lane_clk} == 5'b0, "R9 in reset", 28'({lane_data, lane_clk}), 28'h0);
    rst_n = 1'b1;
    cycles(10);
    chk({lane_data, lane_clk} == 5'b0, "R9 after reset asleep", 28'({lane_data, lane_clk}), 28'h0);
  endtask

  // R1 R2 R4 R5 R7: one frame per pixel, decoded word per frame
  task automatic t_stream(input bit rs, input bit nm, input int salt, input string tag);
    logic [27:0] exp;
    restart(rs, nm);
    drive_pixels(8, 7, salt);
    cycles(20);
    chk(dec_n >= 6, {tag, " R4 frames framed"}, 28'(dec_n), 28'd6);
    for (int k = 0; k < 6; k++) begin
      exp = rs ? wa(k, salt) : ~wa(k, salt);
      if (nm) exp[27:21] = '0;
      chk(dec[k] == exp, {tag, " R1 R2 R5 R7 word"}, dec[k], exp);
    end
  endtask

  // R8: ten-slot pixel period, captures land mid-frame; no torn frames
  task automatic t_drift;
    int j;
    bit hit;
    restart(1'b1, 1'b0);
    drive_pixels(5, 10, 9);
    cycles(40);
    chk(dec_n >= 8, "R8 frame count", 28'(dec_n), 28'd8);
    j = 0;
    for (int f = 0; f < dec_n && f < 12; f++) begin
      hit = 1'b0;
      while (j < 5 && !hit) begin
        if (dec[f] == wa(j, 9)) hit = 1'b1;
        else j++;
      end
      chk(hit, "R8 frame is one whole word in order", dec[f], wa(j < 5 ? j : 4, 9));
    end
  endtask

  // R6 R7: sleep mid-frame, pixel edges while asleep, wake without pixels
  task automatic t_sleep;
    int bad;
    restart(1'b1, 1'b0);
    drive_pixels(3, 7, 4);
    cycles(3);
    wake = 1'b0;
    cycles(1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (i % 7 == 0) begin pix_clk = ~pix_clk; pix_word = wa(i, 5); end
      if ({lane_data, lane_clk} != 5'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6 lanes low asleep", 28'(bad), 28'h0);
    pix_clk = 1'b0;
    cycles(2);
    dec_n = 0;
    wake = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if ({lane_data, lane_clk} != 5'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 no frame before capture", 28'(bad), 28'h0);
    drive_pixels(3, 7, 6);
    cycles(20);
    chk(dec_n >= 1 && dec[0] == wa(0, 6), "R7 first frame after wake", dec[0], wa(0, 6));
  endtask

  // R3: outputs hold steady through the cycle without a slot enable
  task automatic t_hold;
    int bad;
    logic [4:0] prev;
    restart(1'b1, 1'b0);
    fork
      drive_pixels(4, 7, 2);
      begin
        bad = 0;
        cycles(4);
        for (int i = 0; i < 40; i++) begin
          if (bit_en) prev = {lane_data, lane_clk};
          @(negedge clk);
          if (!bit_en && {lane_data, lane_clk} != prev) bad++;
        end
      end
    join
    chk(bad == 0, "R3 no change off slot enable", 28'(bad), 28'h0);
  endtask

  initial begin
    #400us;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream(1'b1, 1'b0, 1, "rise wide");
    t_stream(1'b0, 1'b0, 2, "fall wide");
    t_stream(1'b1, 1'b1, 3, "rise narrow");
    t_stream(1'b0, 1'b1, 7, "fall narrow");
    t_drift();
    t_sleep();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule